// File: doc/BRIEF.md
# Compare Flags and Branch-Condition Unit

This block compares two operands of equal width by subtracting the second from the first. The subtraction runs on an adder: the first operand is added to the bitwise inverse of the second with a carry-in of one. From the difference and the adder's carries it forms four status flags: carry, signed overflow, negative and zero. On a compare request the flags are captured into a flag register, which keeps them until the next compare.

A build-time option picks the meaning of the stored carry. In one setting the carry holds the raw adder carry-out, which is 1 when no borrow occurred. In the other setting the carry-out is inverted so the flag reads as a borrow. A condition evaluator takes a 4-bit condition code and the stored flags and drives a combinational branch-taken output. The unsigned conditions read the carry with the polarity that fits the chosen setting, so they give the same answer in both settings.

Top module: `cmp_branch_unit`

## Requirements
- R1: With BORROW_MODE=0, the stored carry flag equals the raw carry-out of A + ~B + 1, which is 1 exactly when A >= B as unsigned numbers (for example 0111 − 0110 leaves carry 1 and difference 0001).
- R2: With BORROW_MODE=1, the stored carry flag is the inverted carry-out, which is 1 exactly when A < B as unsigned numbers.
- R3: The overflow flag is 1 exactly when A − B does not fit in WIDTH-bit two's complement. This equals the carry into the MSB XOR the carry out of the MSB, and it also equals the rule "A and ~B share an MSB that the difference's MSB does not match".
- R4: The negative flag equals bit WIDTH−1 of (A − B) mod 2^WIDTH. The zero flag is 1 exactly when every bit of that difference is 0.
- R5: When cmp_valid is high at a rising clock edge, all four flags take the values of that compare at that edge. When cmp_valid is low, the flags keep their values, whatever the operands do.
- R6: While rst_n is low, all four flags are 0.
- R7: Condition codes: 0 EQ (Z), 1 NE (!Z), 6 GE (N==V), 7 LT (N!=V), 8 GT (!Z and N==V), 9 LE (Z or N!=V). Each gives the signed result of comparing the last compared A with B.
- R8: Condition codes 2 AE, 3 B, 4 A and 5 BE give the unsigned comparisons A>=B, A<B, A>B and A<=B. They give the same results for BORROW_MODE 0 and 1.
- R9: take is combinational from the stored flags and cond. A compare issued in the same cycle changes take only after the capturing edge.
- R10: Code 15 (ALWAYS) always gives take=1. The undefined codes 10 to 14 always give take=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_valid | input | 1 | Capture the flags of op_a − op_b at this edge |
| op_a | input | WIDTH | First operand (minuend) |
| op_b | input | WIDTH | Second operand (subtrahend) |
| cond | input | 4 | Condition code to evaluate |
| flag_c | output | 1 | Stored carry flag (raw carry-out or borrow, per BORROW_MODE) |
| flag_v | output | 1 | Stored signed-overflow flag |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| take | output | 1 | Branch condition result from the stored flags |

## Verification
Two functions can fall in the same cycle: a new compare being captured, and a branch condition being read from the flags that are already stored. The bench provokes this by raising cmp_valid with fresh operands while cond selects a condition whose answer differs between the old pair and the new pair. Before the edge, take must still match the old pair; after the edge, every condition must match the new pair. Three instances (8-bit borrow mode, and 4-bit in each carry mode) are checked against integer comparisons over all 4-bit operand pairs and random 8-bit pairs.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

   typedef struct packed {
      logic c;
      logic v;
      logic n;
      logic z;
   } cbu_flags_t;

   typedef enum logic [3:0] {
      CC_EQ     = 4'd0,
      CC_NE     = 4'd1,
      CC_AE     = 4'd2,
      CC_B      = 4'd3,
      CC_A      = 4'd4,
      CC_BE     = 4'd5,
      CC_GE     = 4'd6,
      CC_LT     = 4'd7,
      CC_GT     = 4'd8,
      CC_LE     = 4'd9,
      CC_ALWAYS = 4'd15
   } cbu_cond_e;

endpackage

// File: rtl/cbu_subtractor.sv
module cbu_subtractor #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] diff_o,
   output logic             cout_o,
   output logic             cmsb_o
);
   logic [WIDTH:0] cy;

   assign cy[0] = 1'b1;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic b_inv;
      logic prop;
      assign b_inv     = ~b_i[i];
      assign prop      = a_i[i] ^ b_inv;
      assign diff_o[i] = prop ^ cy[i];
      assign cy[i+1]   = (a_i[i] & b_inv) | (cy[i] & prop);
   end

   assign cout_o = cy[WIDTH];
   assign cmsb_o = cy[WIDTH-1];
endmodule

// File: rtl/cbu_flag_gen.sv
module cbu_flag_gen
   import cbu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int BORROW_MODE = 1
) (
   input  logic [WIDTH-1:0] diff_i,
   input  logic             cout_i,
   input  logic             cmsb_i,
   output cbu_flags_t       flags_o
);
   logic carry_flag;

   if (BORROW_MODE != 0) begin : g_borrow
      assign carry_flag = ~cout_i;
   end else begin : g_raw
      assign carry_flag = cout_i;
   end

   always_comb begin
      flags_o.c = carry_flag;
      flags_o.v = cmsb_i ^ cout_i;
      flags_o.n = diff_i[WIDTH-1];
      flags_o.z = ~|diff_i;
   end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
   import cbu_pkg::*;
#(
   parameter int BORROW_MODE = 1
) (
   input  cbu_flags_t flags_i,
   input  logic [3:0] cond_i,
   output logic       take_o
);
   logic no_borrow;
   logic sgn_ge;

   if (BORROW_MODE != 0) begin : g_borrow
      assign no_borrow = ~flags_i.c;
   end else begin : g_raw
      assign no_borrow = flags_i.c;
   end

   assign sgn_ge = (flags_i.n == flags_i.v);

   always_comb begin
      case (cond_i)
         CC_EQ:     take_o = flags_i.z;
         CC_NE:     take_o = ~flags_i.z;
         CC_AE:     take_o = no_borrow;
         CC_B:      take_o = ~no_borrow;
         CC_A:      take_o = no_borrow & ~flags_i.z;
         CC_BE:     take_o = ~no_borrow | flags_i.z;
         CC_GE:     take_o = sgn_ge;
         CC_LT:     take_o = ~sgn_ge;
         CC_GT:     take_o = ~flags_i.z & sgn_ge;
         CC_LE:     take_o = flags_i.z | ~sgn_ge;
         CC_ALWAYS: take_o = 1'b1;
         default:   take_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
   import cbu_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int BORROW_MODE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_valid,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic [3:0]       cond,
   output logic             flag_c,
   output logic             flag_v,
   output logic             flag_n,
   output logic             flag_z,
   output logic             take
);
   if (WIDTH < 2) begin : g_bad_width
      $error("cmp_branch_unit: WIDTH must be at least 2");
   end
   if (BORROW_MODE != 0 && BORROW_MODE != 1) begin : g_bad_mode
      $error("cmp_branch_unit: BORROW_MODE must be 0 or 1");
   end

   logic [WIDTH-1:0] diff;
   logic             cout;
   logic             cmsb;
   cbu_flags_t       flags_d;
   cbu_flags_t       flags_q;

   cbu_subtractor #(.WIDTH(WIDTH)) u_sub (
      .a_i    (op_a),
      .b_i    (op_b),
      .diff_o (diff),
      .cout_o (cout),
      .cmsb_o (cmsb)
   );

   cbu_flag_gen #(.WIDTH(WIDTH), .BORROW_MODE(BORROW_MODE)) u_fgen (
      .diff_i  (diff),
      .cout_i  (cout),
      .cmsb_i  (cmsb),
      .flags_o (flags_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
      end else if (cmp_valid) begin
         flags_q <= flags_d;
      end
   end

   cbu_cond_eval #(.BORROW_MODE(BORROW_MODE)) u_ceval (
      .flags_i (flags_q),
      .cond_i  (cond),
      .take_o  (take)
   );

   assign flag_c = flags_q.c;
   assign flag_v = flags_q.v;
   assign flag_n = flags_q.n;
   assign flag_z = flags_q.z;
endmodule

// File: rtl/cbu_chk.sv
module cbu_chk #(
   parameter int WIDTH       = 8,
   parameter int BORROW_MODE = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmp_valid,
   input logic [WIDTH-1:0] op_a,
   input logic [WIDTH-1:0] op_b,
   input logic [3:0]       cond,
   input logic             flag_c,
   input logic             flag_v,
   input logic             flag_n,
   input logic             flag_z,
   input logic             take
);
   logic [WIDTH-1:0] ref_diff;
   logic             ref_ovf;
   logic             ref_c;

   assign ref_diff = op_a - op_b;
   assign ref_ovf  = (op_a[WIDTH-1] != op_b[WIDTH-1]) && (ref_diff[WIDTH-1] != op_a[WIDTH-1]);
   assign ref_c    = (BORROW_MODE != 0) ? (op_a < op_b) : (op_a >= op_b);

   // R1 R2
   carry_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_valid) && $past(rst_n) |-> flag_c == $past(ref_c));

   // R3
   ovf_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_valid) && $past(rst_n) |-> flag_v == $past(ref_ovf));

   // R4
   nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_valid) && $past(rst_n) |->
         (flag_n == $past(ref_diff[WIDTH-1])) && (flag_z == $past(op_a == op_b)));

   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmp_valid) && $past(rst_n) |-> $stable({flag_c, flag_v, flag_n, flag_z}));

   // R8
   ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmp_valid) && $past(rst_n) && cond == 4'd2 |-> take == $past(op_a >= op_b));

   // R10
   undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cond >= 4'd10 && cond <= 4'd14) |-> !take);

   // R10
   always_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cond == 4'd15 |-> take);
endmodule

bind cmp_branch_unit cbu_chk #(.WIDTH(WIDTH), .BORROW_MODE(BORROW_MODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmp_valid (cmp_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .cond      (cond),
   .flag_c    (flag_c),
   .flag_v    (flag_v),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .take      (take)
);

// File: tb/cmp_branch_unit_tb.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_valid = 1'b0;
   logic [7:0] op_a = '0;
   logic [7:0] op_b = '0;
   logic [3:0] cond = '0;

   logic c8, v8, n8, z8, t8;
   logic c4b, v4b, n4b, z4b, t4b;
   logic c4r, v4r, n4r, z4r, t4r;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cmp_branch_unit #(.WIDTH(8), .BORROW_MODE(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .op_a(op_a), .op_b(op_b),
      .cond(cond), .flag_c(c8), .flag_v(v8), .flag_n(n8), .flag_z(z8), .take(t8));

   cmp_branch_unit #(.WIDTH(4), .BORROW_MODE(1)) u_dut_w4b (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .op_a(op_a[3:0]), .op_b(op_b[3:0]),
      .cond(cond), .flag_c(c4b), .flag_v(v4b), .flag_n(n4b), .flag_z(z4b), .take(t4b));

   cmp_branch_unit #(.WIDTH(4), .BORROW_MODE(0)) u_dut_w4r (
      .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .op_a(op_a[3:0]), .op_b(op_b[3:0]),
      .cond(cond), .flag_c(c4r), .flag_v(v4r), .flag_n(n4r), .flag_z(z4r), .take(t4r));

   function automatic int to_signed(int u, int w);
      return (u >= (1 << (w - 1))) ? u - (1 << w) : u;
   endfunction

   function automatic bit ref_cond(int code, int ua, int ub, int w);
      int sa = to_signed(ua, w);
      int sb = to_signed(ub, w);
      case (code)
         0:  return ua == ub;
         1:  return ua != ub;
         2:  return ua >= ub;
         3:  return ua <  ub;
         4:  return ua >  ub;
         5:  return ua <= ub;
         6:  return sa >= sb;
         7:  return sa <  sb;
         8:  return sa >  sb;
         9:  return sa <= sb;
         15: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   // returns {c, v, n, z}
   function automatic logic [3:0] ref_flags(int ua, int ub, int w, int mode);
      int d  = (ua - ub) & ((1 << w) - 1);
      int sd = to_signed(ua, w) - to_signed(ub, w);
      logic c, v, n, z;
      c = (mode != 0) ? (ua < ub) : (ua >= ub);
      v = (sd > (1 << (w - 1)) - 1) || (sd < -(1 << (w - 1)));
      n = ((d >> (w - 1)) & 1) != 0;
      z = (d == 0);
      return {c, v, n, z};
   endfunction

   task automatic chk(logic got, logic exp, string req, string what);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0b expected=%0b (a=%0h b=%0h cond=%0d)",
                  req, what, got, exp, op_a, op_b, cond);
      end
   endtask

   function automatic string cond_req(int code);
      if (code >= 2 && code <= 5) return "R8";
      if (code >= 10) return "R10";
      return "R7";
   endfunction

   task automatic check_flags(logic [3:0] got, logic [3:0] exp, string creq, string who);
      chk(got[3], exp[3], creq, {who, " flag_c"});
      chk(got[2], exp[2], "R3", {who, " flag_v"});
      chk(got[1], exp[1], "R4", {who, " flag_n"});
      chk(got[0], exp[0], "R4", {who, " flag_z"});
   endtask

   // Checks stored flags and every condition code against the pair (a, b).
   task automatic verify(int a, int b);
      check_flags({c8, v8, n8, z8},     ref_flags(a, b, 8, 1),            "R2", "w8");
      check_flags({c4b, v4b, n4b, z4b}, ref_flags(a & 15, b & 15, 4, 1), "R2", "w4b");
      check_flags({c4r, v4r, n4r, z4r}, ref_flags(a & 15, b & 15, 4, 0), "R1", "w4r");
      for (int code = 0; code < 16; code++) begin
         cond = 4'(code);
         #0.1;
         chk(t8,  ref_cond(code, a, b, 8),           cond_req(code), "w8 take");
         chk(t4b, ref_cond(code, a & 15, b & 15, 4), cond_req(code), "w4b take");
         chk(t4r, ref_cond(code, a & 15, b & 15, 4), cond_req(code), "w4r take");
      end
   endtask

   task automatic do_cmp(int a, int b);
      @(negedge clk);
      op_a = 8'(a);
      op_b = 8'(b);
      cmp_valid = 1'b1;
      @(negedge clk);
      cmp_valid = 1'b0;
      verify(a, b);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));

      // R6: flags cleared during reset
      repeat (2) @(negedge clk);
      chk(c8 | v8 | n8 | z8, 1'b0, "R6", "w8 flags in reset");
      chk(c4r | v4r | n4r | z4r, 1'b0, "R6", "w4r flags in reset");
      cond = 4'd1;
      #0.1;
      chk(t8, 1'b1, "R6", "NE taken with cleared Z");
      rst_n = 1'b1;

      // Directed corners, including 0111 - 0110
      do_cmp(8'h07, 8'h06);
      do_cmp(8'h80, 8'h01);
      do_cmp(8'h7F, 8'hFF);
      do_cmp(8'h00, 8'h00);
      do_cmp(8'hFF, 8'h00);
      do_cmp(8'h00, 8'h80);

      // R5: operands change without cmp_valid; flags must stay on the old pair
      do_cmp(8'h35, 8'h35);
      @(negedge clk);
      op_a = 8'h01;
      op_b = 8'hF8;
      @(negedge clk);
      verify(8'h35, 8'h35);

      // R9: new compare issued while branch reads the old flags
      do_cmp(8'h10, 8'h20);
      @(negedge clk);
      op_a = 8'h20;
      op_b = 8'h10;
      cmp_valid = 1'b1;
      cond = 4'd2;
      #0.5;
      chk(t8, 1'b0, "R9", "AE before capture edge");
      @(negedge clk);
      cmp_valid = 1'b0;
      verify(8'h20, 8'h10);

      // Exhaustive 4-bit pairs, random upper nibble for the 8-bit instance
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            do_cmp((($urandom % 16) << 4) | a, (($urandom % 16) << 4) | b);
         end
      end

      // Random 8-bit pairs, with a bias toward equal and near-equal values
      for (int i = 0; i < 300; i++) begin
         int ra = $urandom % 256;
         int rb;
         case ($urandom % 4)
            0:       rb = ra;
            1:       rb = (ra + 1) % 256;
            default: rb = $urandom % 256;
         endcase
         do_cmp(ra, rb);
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule